// File: doc/BRIEF.md
# Longest Propagate Run Analyzer

This block inspects a pair of N-bit addition operands and finds where a carry would ripple through the longest unbroken stretch of positions. A position propagates when exactly one of its two operand bits is set. A chain is a maximal run of adjacent propagating positions. The block reports the length of the longest chain as the pair's weight, together with the lowest and highest bit index of that chain.

Pairs with the same weight fall into the same class. Classes are ranked by weight, so a single cutoff separates harmless pairs from vulnerable ones. The block compares the weight against a threshold input and raises a vulnerable flag at or above it.

A parameter selects the output timing. With registering on, every result and the valid strobe leave one clock after the operands. With registering off, the outputs follow the inputs combinationally. The block is meant to sit beside an adder, so that operand pairs with long ripple paths can be identified and routed to a faster path.

Top module: `prop_run_analyzer`

## Requirements
- R1: Bit k propagates when opnd_a[k] XOR opnd_b[k] is 1. The reported run_start and run_finish bound a maximal run of propagating bits. Both ends propagate, and the neighbours just outside the run (where they exist) do not.
- R2: weight equals run_finish - run_start + 1 for the longest run and lies in 0..WIDTH. An all-propagating pair gives weight WIDTH, run_start 0 and run_finish WIDTH-1.
- R3: When several runs share the longest length, the run with the lowest start index is reported.
- R4: When no bit propagates, weight, run_start and run_finish are all 0.
- R5: vulnerable is 1 exactly when weight >= vuln_threshold, compared unsigned. A threshold of 0 marks every pair vulnerable, including one of weight 0.
- R6: With REGISTERED=1, the results for operands sampled with in_valid high appear after that rising edge, and out_valid is in_valid delayed by one clock.
- R7: With REGISTERED=1, an edge with in_valid low leaves weight, run_start, run_finish and vulnerable unchanged and drives out_valid to 0.
- R8: With REGISTERED=1, an asynchronous active-low reset clears every output to 0.
- R9: With REGISTERED=0, all results follow the inputs within the same cycle, and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and threshold are valid this cycle |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| vuln_threshold | input | $clog2(WIDTH+1) | Weight at or above which a pair is flagged |
| out_valid | output | 1 | Results are valid |
| weight | output | $clog2(WIDTH+1) | Length of the longest propagate run |
| run_start | output | $clog2(WIDTH) | Lowest bit index of that run |
| run_finish | output | $clog2(WIDTH) | Highest bit index of that run |
| vulnerable | output | 1 | Weight has reached the threshold |

## Verification
Uniform random operands almost never produce long runs, because a run of length L appears with a probability of roughly 2^-L. Random pairs therefore cannot reach the top weights, or ties between two long runs. The stimulus builds the propagate mask on purpose: it sets long contiguous spans at random offsets and then derives opnd_b as opnd_a XOR mask. Directed masks cover the rest: two equal separated runs, the all-propagating word, single bits at either edge, and the alternating patterns.

// File: rtl/prop_run_pkg.sv
package prop_run_pkg;

  // Lowest index of a run, given its highest index and its length.
  function automatic logic [31:0] run_start_of(logic [31:0] fin, logic [31:0] len);
    return (len == 32'd0) ? 32'd0 : (fin - len + 32'd1);
  endfunction

  // Classification cut: at or above the threshold means vulnerable.
  function automatic logic meets_threshold(logic [31:0] wt, logic [31:0] thr);
    return wt >= thr;
  endfunction

endpackage

// File: rtl/prop_mask_gen.sv
module prop_mask_gen #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] prop_mask
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign prop_mask[k] = opnd_a[k] ^ opnd_b[k];
  end
endmodule

// File: rtl/run_length_scan.sv
module run_length_scan #(
  parameter int WIDTH = 32,
  parameter int WT_W  = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0]           prop_mask,
  output logic [WIDTH-1:0][WT_W-1:0] run_len
);
  // run_len[k]: number of consecutive propagating bits ending at bit k.
  for (genvar k = 0; k < WIDTH; k++) begin : g_len
    if (k == 0) begin : g_lsb
      assign run_len[k] = prop_mask[k] ? WT_W'(1) : '0;
    end else begin : g_up
      assign run_len[k] = prop_mask[k] ? (run_len[k-1] + WT_W'(1)) : '0;
    end
  end
endmodule

// File: rtl/run_pick.sv
module run_pick
  import prop_run_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int WT_W  = $clog2(WIDTH + 1),
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0][WT_W-1:0] run_len,
  output logic [WT_W-1:0]            best_wt,
  output logic [IDX_W-1:0]           best_fin,
  output logic [IDX_W-1:0]           best_start
);
  logic [WT_W-1:0]  scan_wt;
  logic [IDX_W-1:0] scan_fin;

  // Strict comparison keeps the first (lowest) end index on ties.
  always_comb begin
    scan_wt  = '0;
    scan_fin = '0;
    for (int k = 0; k < WIDTH; k++) begin
      if (run_len[k] > scan_wt) begin
        scan_wt  = run_len[k];
        scan_fin = IDX_W'(k);
      end
    end
  end

  assign best_wt    = scan_wt;
  assign best_fin   = scan_fin;
  assign best_start = IDX_W'(run_start_of(32'(scan_fin), 32'(scan_wt)));
endmodule

// File: rtl/prop_run_analyzer.sv
module prop_run_analyzer
  import prop_run_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter bit REGISTERED = 1'b1,
  localparam int WT_W      = $clog2(WIDTH + 1),
  localparam int IDX_W     = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WIDTH-1:0]  opnd_a,
  input  logic [WIDTH-1:0]  opnd_b,
  input  logic [WT_W-1:0]   vuln_threshold,
  output logic              out_valid,
  output logic [WT_W-1:0]   weight,
  output logic [IDX_W-1:0]  run_start,
  output logic [IDX_W-1:0]  run_finish,
  output logic              vulnerable
);
  logic [WIDTH-1:0]           prop_mask;
  logic [WIDTH-1:0][WT_W-1:0] run_len;
  logic [WT_W-1:0]            core_wt;
  logic [IDX_W-1:0]           core_fin;
  logic [IDX_W-1:0]           core_start;
  logic                       core_vuln;

  prop_mask_gen #(.WIDTH(WIDTH)) u_mask (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .prop_mask (prop_mask)
  );

  run_length_scan #(.WIDTH(WIDTH), .WT_W(WT_W)) u_scan (
    .prop_mask (prop_mask),
    .run_len   (run_len)
  );

  run_pick #(.WIDTH(WIDTH), .WT_W(WT_W), .IDX_W(IDX_W)) u_pick (
    .run_len    (run_len),
    .best_wt    (core_wt),
    .best_fin   (core_fin),
    .best_start (core_start)
  );

  assign core_vuln = meets_threshold(32'(core_wt), 32'(vuln_threshold));

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid  <= 1'b0;
        weight     <= '0;
        run_start  <= '0;
        run_finish <= '0;
        vulnerable <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          weight     <= core_wt;
          run_start  <= core_start;
          run_finish <= core_fin;
          vulnerable <= core_vuln;
        end
      end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                            // R6
    AST_WEIGHT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (weight == $past(core_wt)));                           // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(weight) && $stable(run_finish))); // R7
  end else begin : g_comb
    assign out_valid  = in_valid;
    assign weight     = core_wt;
    assign run_start  = core_start;
    assign run_finish = core_fin;
    assign vulnerable = core_vuln;
  end

  // Independent views of the chosen run, taken from the mask itself.
  logic run_left_closed;
  logic run_right_closed;
  assign run_left_closed  = (core_start == '0) || !prop_mask[core_start - IDX_W'(1)];
  assign run_right_closed = (core_fin == IDX_W'(WIDTH - 1)) || !prop_mask[core_fin + IDX_W'(1)];

  AST_RUN_ENDS_PROPAGATE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && core_wt != '0) |-> (prop_mask[core_fin] && prop_mask[core_start])); // R1
  AST_RUN_MAXIMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && core_wt != '0) |-> (run_left_closed && run_right_closed));   // R1
  AST_WEIGHT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (32'(core_wt) <= $countones(prop_mask)));                    // R2
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prop_mask == '0) |-> (core_wt == '0 && core_fin == '0 && core_start == '0)); // R4
endmodule

// File: tb/test_prop_run_analyzer.sv
module test_prop_run_analyzer;
  localparam int W   = 32;
  localparam int WTW = $clog2(W + 1);
  localparam int IXW = $clog2(W);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [W-1:0]   a = '0;
  logic [W-1:0]   b = '0;
  logic [WTW-1:0] thr = '0;

  logic           r_valid, c_valid, r_vuln, c_vuln;
  logic [WTW-1:0] r_wt, c_wt;
  logic [IXW-1:0] r_st, c_st, r_fin, c_fin;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prop_run_analyzer #(.WIDTH(W), .REGISTERED(1'b1)) i_prop_run_analyzer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(a), .opnd_b(b),
    .vuln_threshold(thr), .out_valid(r_valid), .weight(r_wt),
    .run_start(r_st), .run_finish(r_fin), .vulnerable(r_vuln));

  prop_run_analyzer #(.WIDTH(W), .REGISTERED(1'b0)) i_prop_run_analyzer_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(a), .opnd_b(b),
    .vuln_threshold(thr), .out_valid(c_valid), .weight(c_wt),
    .run_start(c_st), .run_finish(c_fin), .vulnerable(c_vuln));

  // Reference: walk the bits from the bottom, track the current run and
  // keep the first run that is strictly longer than any seen before.
  int e_wt, e_st, e_fin;
  bit e_vuln;
  task automatic model(input logic [W-1:0] x, input logic [W-1:0] y, input int t);
    int cur = 0;
    e_wt = 0; e_st = 0; e_fin = 0;
    for (int k = 0; k < W; k++) begin
      cur = (x[k] != y[k]) ? cur + 1 : 0;
      if (cur > e_wt) begin
        e_wt  = cur;
        e_fin = k;
        e_st  = k - cur + 1;
      end
    end
    e_vuln = (e_wt >= t);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input bit regd);
    check({tag, " R2"}, regd ? "reg weight" : "comb weight", regd ? int'(r_wt) : int'(c_wt), e_wt);
    check({tag, " R1/R3"}, regd ? "reg start" : "comb start", regd ? int'(r_st) : int'(c_st), e_st);
    check({tag, " R1"}, regd ? "reg finish" : "comb finish", regd ? int'(r_fin) : int'(c_fin), e_fin);
    check({tag, " R5"}, regd ? "reg vuln" : "comb vuln", regd ? int'(r_vuln) : int'(c_vuln), int'(e_vuln));
  endtask

  // Drive after a falling edge, check the combinational copy at once,
  // then check the registered copy after the next rising edge.
  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input int t, input string tag);
    @(negedge clk);
    a = x; b = y; thr = WTW'(t); in_valid = 1'b1;
    model(x, y, t);
    #1;
    check_all({tag, " R9"}, 1'b0);
    check("R9", "comb valid", int'(c_valid), 1);
    @(negedge clk);
    check_all({tag, " R6"}, 1'b1);
    check("R6", "reg valid", int'(r_valid), 1);
  endtask

  function automatic logic [W-1:0] span(input int lo, input int len);
    logic [W-1:0] m = '0;
    for (int k = 0; k < len; k++)
      if (lo + k < W) m[lo + k] = 1'b1;
    return m;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, mk;
    int sw, sv, sf;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "reset weight", int'(r_wt), 0);
    check("R8", "reset valid", int'(r_valid), 0);
    check("R8", "reset vuln", int'(r_vuln), 0);
    check("R8", "reset finish", int'(r_fin), 0);
    rst_n = 1'b1;

    apply('0, '0, 1, "R4 none");
    apply(32'h1234_5678, 32'h1234_5678, 0, "R4 equal thr0");
    apply('1, '0, W, "R2 all-prop");
    apply('0, '1, W + 1, "R2 all-prop above");
    apply(32'hAAAA_AAAA, '0, 1, "R3 alternating");
    apply(32'h5555_5555, '0, 2, "R3 alternating low");
    apply(32'h00F0_00F0, '0, 4, "R3 twin runs");
    apply(32'h8000_0000, '0, 1, "R1 top bit");
    apply(32'h0000_0001, '0, 2, "R1 bottom bit");
    apply(32'hFFFF_0000, 32'h0000_FFFF, 31, "R2 full via both");
    apply(32'h0FF0_0FF0, 32'h0000_0000, 8, "R5 at threshold");
    apply(32'h0FF0_0FF0, 32'h0000_0000, 9, "R5 below threshold");

    // R7: idle edge with new operands must leave results alone.
    model(32'h0FF0_0FF0, '0, 9);
    @(negedge clk);
    in_valid = 1'b0; a = '1; b = '0; thr = '0;
    @(negedge clk);
    check("R7", "idle valid", int'(r_valid), 0);
    check("R7", "idle weight", int'(r_wt), e_wt);
    check("R7", "idle finish", int'(r_fin), e_fin);
    check("R7", "idle vuln", int'(r_vuln), int'(e_vuln));
    sw = e_wt; sv = e_st; sf = e_fin;
    @(negedge clk);
    check("R7", "idle2 start", int'(r_st), sv);

    for (int n = 0; n < 300; n++) begin
      ra = $urandom;
      if (n % 2 == 0) mk = $urandom;
      else mk = span($urandom_range(W - 1), $urandom_range(W, 1)) | span($urandom_range(W - 1), $urandom_range(8, 1));
      apply(ra, ra ^ mk, $urandom_range(W + 2), n % 2 == 0 ? "R1 random" : "R2 dense");
    end
    // Equal long runs at random spacing for the tie rule.
    for (int n = 0; n < 40; n++) begin
      int len = $urandom_range(8, 2);
      int lo = $urandom_range(W / 2 - len - 1);
      ra = $urandom;
      mk = span(lo, len) | span(lo + len + 1 + $urandom_range(W / 2 - 1 - len), len);
      apply(ra, ra ^ mk, len, "R3 random ties");
    end
    if (sw < 0 || sf < 0) miscompares++;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule